// File: doc/BRIEF.md
# Two-Clock Bypass Mailbox Pair

This block lets the two ports of a bidirectional buffer send single words straight to each other. It carries one word at a time in each direction, and no deep storage sits in the path. Port A and Port B each run on their own clock. Each direction has one holding register. The sending port loads it, and the receiving port unloads it. A toggle request travels across the clock boundary, and a toggle acknowledge travels back. A "full" flag in the sender's domain tells the sender whether the slot is occupied. A "data waiting" flag in the receiver's domain tells the receiver whether a word has arrived.

Bypass mode is a level on a Port A control input. The block registers it in the Port A domain and passes it through a two-flop synchronizer to Port B. There it appears as an active-low indicator. A transfer starts only while the local copy of the mode is on.

Each port runs a single enable/direction pair instead of separate valid and ready signals:

- A write is offered when the enable is low and the direction is 0. The full flag is the ready signal, so a write offered while full is dropped.
- A read is offered when the enable is low and the direction is 1. The waiting flag is the valid signal, so a read offered while it is low is dropped.

The sender must keep offering a word, or re-offer it, until the full flag is high.

Top module: `bypass_mailbox`

## Requirements
- R1: In bypass mode, an accepted Port A write loads the A-to-B slot. An accepted write is `a_en_n`=0 and `a_dir`=0 at a `clk_a` rising edge while `a_ab_full_n`=1. After that edge `a_ab_full_n` reads 0.
- R2: Once the A-to-B word reaches Port B, `b_ab_empty_n` goes to 1. A Port B read (`b_en_n`=0, `b_dir`=1) then puts the word on `b_rdata` after that `clk_b` edge, and `b_ab_empty_n` drops to 0 after the same edge.
- R3: After Port B has taken the A-to-B word, `a_ab_full_n` returns to 1 within a few `clk_a` cycles, and Port A may then write a new word.
- R4: The B-to-A direction works the same way with the roles swapped. Port B writes with `b_dir`=0, `b_ba_full_n` goes low, and `a_ba_empty_n` goes high. Port A reads with `a_dir`=1, and the word appears on `a_rdata`. `a_ba_empty_n` goes low on the cycle after that read.
- R5: A write offered while the slot is occupied is ignored. The flags stay as they were, and the word delivered is the earlier one.
- R6: A read offered while no word is waiting is ignored. The read data output and the flags keep their values.
- R7: While a port's `*_en_n` is 1, that port transfers nothing.
- R8: While bypass mode is off in a port's domain, that port accepts no write and no read.
- R9: `b_byp_n` goes low after `a_bypass` is raised and high after it is lowered. The change passes through one `clk_a` register and two `clk_b` registers.
- R10: While `rst_n` is 0, both slots are empty, `a_ab_full_n` and `b_ba_full_n` are 1, `a_ba_empty_n` and `b_ab_empty_n` are 0, and bypass is off (`b_byp_n`=1).
- R11: A word is delivered unaltered across unrelated clocks. A slot's read data output changes only on an accepted read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_a | input | 1 | Port A clock |
| clk_b | input | 1 | Port B clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| a_bypass | input | 1 | Bypass mode request from Port A |
| a_en_n | input | 1 | Port A transfer enable, active low |
| a_dir | input | 1 | Port A direction: 0 write, 1 read |
| a_wdata | input | DATA_W | Word Port A sends to B |
| a_rdata | output | DATA_W | Last word Port A took from B |
| a_ab_full_n | output | 1 | Low while the A-to-B slot is occupied |
| a_ba_empty_n | output | 1 | High while a B-to-A word waits for Port A |
| b_en_n | input | 1 | Port B transfer enable, active low |
| b_dir | input | 1 | Port B direction: 0 write, 1 read |
| b_wdata | input | DATA_W | Word Port B sends to A |
| b_rdata | output | DATA_W | Last word Port B took from A |
| b_ab_empty_n | output | 1 | High while an A-to-B word waits for Port B |
| b_ba_full_n | output | 1 | Low while the B-to-A slot is occupied |
| b_byp_n | output | 1 | Low while bypass mode is on (Port B view) |

## Verification
Port A can read the B-to-A slot on the same `clk_a` edge that the A-to-B acknowledge lands and raises `a_ab_full_n`. Port B can likewise write on the edge where its A-to-B request arrives. The vector loop provokes these collisions by running both directions in every step, with the clocks at unrelated periods, so the arrival edges sweep across the phase space. Each pair is judged by the delivered word on both sides and by every flag settling to its idle value before the next step.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  typedef enum logic {
    XFER_WR = 1'b0,
    XFER_RD = 1'b1
  } xfer_dir_e;
endpackage

// File: rtl/mbx_sync.sv
module mbx_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage_q[s] <= '0;
      else if (s == 0) stage_q[s] <= d;
      else stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
    end
  end

  assign q = stage_q[STAGES-1];
endmodule

// File: rtl/mbx_channel.sv
module mbx_channel
  import mbx_pkg::*;
#(
  parameter int DATA_W = 18,
  parameter int STAGES = 2
) (
  input  logic              wclk,
  input  logic              rclk,
  input  logic              rst_n,
  input  logic              w_mode,
  input  logic              w_en_n,
  input  logic              w_dir,
  input  logic [DATA_W-1:0] w_data,
  output logic              w_full_n,
  input  logic              r_mode,
  input  logic              r_en_n,
  input  logic              r_dir,
  output logic [DATA_W-1:0] r_data,
  output logic              r_empty_n
);
  logic [DATA_W-1:0] hold_q;
  logic [DATA_W-1:0] rd_q;
  logic              req_tgl_q, ack_tgl_q;
  logic              req_at_r, ack_at_w;
  logic              occupied, waiting;
  logic              w_fire, r_fire;

  assign occupied = req_tgl_q != ack_at_w;
  assign waiting  = req_at_r != ack_tgl_q;
  assign w_fire   = w_mode && !w_en_n && (w_dir == XFER_WR) && !occupied;
  assign r_fire   = r_mode && !r_en_n && (r_dir == XFER_RD) && waiting;

  always_ff @(posedge wclk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q    <= '0;
      req_tgl_q <= 1'b0;
    end else if (w_fire) begin
      hold_q    <= w_data;
      req_tgl_q <= ~req_tgl_q;
    end
  end

  always_ff @(posedge rclk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q      <= '0;
      ack_tgl_q <= 1'b0;
    end else if (r_fire) begin
      rd_q      <= hold_q;
      ack_tgl_q <= ~ack_tgl_q;
    end
  end

  mbx_sync #(.W(1), .STAGES(STAGES)) req_sync_i (
    .clk(rclk), .rst_n(rst_n), .d(req_tgl_q), .q(req_at_r));

  mbx_sync #(.W(1), .STAGES(STAGES)) ack_sync_i (
    .clk(wclk), .rst_n(rst_n), .d(ack_tgl_q), .q(ack_at_w));

  assign w_full_n  = ~occupied;
  assign r_empty_n = waiting;
  assign r_data    = rd_q;
endmodule

// File: rtl/bypass_mailbox.sv
module bypass_mailbox #(
  parameter int DATA_W = 18,
  parameter int STAGES = 2
) (
  input  logic              clk_a,
  input  logic              clk_b,
  input  logic              rst_n,
  input  logic              a_bypass,
  input  logic              a_en_n,
  input  logic              a_dir,
  input  logic [DATA_W-1:0] a_wdata,
  output logic [DATA_W-1:0] a_rdata,
  output logic              a_ab_full_n,
  output logic              a_ba_empty_n,
  input  logic              b_en_n,
  input  logic              b_dir,
  input  logic [DATA_W-1:0] b_wdata,
  output logic [DATA_W-1:0] b_rdata,
  output logic              b_ab_empty_n,
  output logic              b_ba_full_n,
  output logic              b_byp_n
);
  logic mode_a_q;
  logic mode_b;

  always_ff @(posedge clk_a or negedge rst_n) begin
    if (!rst_n) mode_a_q <= 1'b0;
    else        mode_a_q <= a_bypass;
  end

  mbx_sync #(.W(1), .STAGES(STAGES)) mode_sync_i (
    .clk(clk_b), .rst_n(rst_n), .d(mode_a_q), .q(mode_b));

  assign b_byp_n = ~mode_b;

  mbx_channel #(.DATA_W(DATA_W), .STAGES(STAGES)) ab_i (
    .wclk(clk_a), .rclk(clk_b), .rst_n(rst_n),
    .w_mode(mode_a_q), .w_en_n(a_en_n), .w_dir(a_dir), .w_data(a_wdata),
    .w_full_n(a_ab_full_n),
    .r_mode(mode_b), .r_en_n(b_en_n), .r_dir(b_dir), .r_data(b_rdata),
    .r_empty_n(b_ab_empty_n));

  mbx_channel #(.DATA_W(DATA_W), .STAGES(STAGES)) ba_i (
    .wclk(clk_b), .rclk(clk_a), .rst_n(rst_n),
    .w_mode(mode_b), .w_en_n(b_en_n), .w_dir(b_dir), .w_data(b_wdata),
    .w_full_n(b_ba_full_n),
    .r_mode(mode_a_q), .r_en_n(a_en_n), .r_dir(a_dir), .r_data(a_rdata),
    .r_empty_n(a_ba_empty_n));
endmodule

// File: rtl/bypass_mailbox_chk.sv
module bypass_mailbox_chk #(
  parameter int DATA_W = 18
) (
  input logic              clk_a,
  input logic              clk_b,
  input logic              rst_n,
  input logic              mode_a,
  input logic              mode_b,
  input logic              a_en_n,
  input logic              a_dir,
  input logic [DATA_W-1:0] a_rdata,
  input logic              a_ab_full_n,
  input logic              a_ba_empty_n,
  input logic              b_en_n,
  input logic              b_dir,
  input logic [DATA_W-1:0] b_rdata,
  input logic              b_ab_empty_n,
  input logic              b_ba_full_n
);
  logic a_wr_ok, a_rd_ok, b_wr_ok, b_rd_ok;
  assign a_wr_ok = mode_a && !a_en_n && !a_dir && a_ab_full_n;
  assign a_rd_ok = mode_a && !a_en_n &&  a_dir && a_ba_empty_n;
  assign b_wr_ok = mode_b && !b_en_n && !b_dir && b_ba_full_n;
  assign b_rd_ok = mode_b && !b_en_n &&  b_dir && b_ab_empty_n;

  p_load_sets_full_r1: assert property (@(posedge clk_a) disable iff (!rst_n)
    a_wr_ok |=> !a_ab_full_n);

  p_read_clears_wait_r2: assert property (@(posedge clk_b) disable iff (!rst_n)
    b_rd_ok |=> !b_ab_empty_n);

  p_ba_load_sets_full_r4: assert property (@(posedge clk_b) disable iff (!rst_n)
    b_wr_ok |=> !b_ba_full_n);

  p_ba_read_clears_wait_r4: assert property (@(posedge clk_a) disable iff (!rst_n)
    a_rd_ok |=> !a_ba_empty_n);

  p_brdata_hold_r11: assert property (@(posedge clk_b) disable iff (!rst_n)
    !b_rd_ok |=> $stable(b_rdata));

  p_ardata_hold_r6: assert property (@(posedge clk_a) disable iff (!rst_n)
    !a_rd_ok |=> $stable(a_rdata));

  always @(posedge clk_a) begin
    if (!rst_n) begin
      p_reset_flags_a_r10: assert (a_ab_full_n && !a_ba_empty_n);
    end
  end

  always @(posedge clk_b) begin
    if (!rst_n) begin
      p_reset_flags_b_r10: assert (b_ba_full_n && !b_ab_empty_n);
    end
  end
endmodule

bind bypass_mailbox bypass_mailbox_chk #(.DATA_W(DATA_W)) chk_i (
  .clk_a(clk_a), .clk_b(clk_b), .rst_n(rst_n),
  .mode_a(mode_a_q), .mode_b(mode_b),
  .a_en_n(a_en_n), .a_dir(a_dir), .a_rdata(a_rdata),
  .a_ab_full_n(a_ab_full_n), .a_ba_empty_n(a_ba_empty_n),
  .b_en_n(b_en_n), .b_dir(b_dir), .b_rdata(b_rdata),
  .b_ab_empty_n(b_ab_empty_n), .b_ba_full_n(b_ba_full_n));

// File: tb/bypass_mailbox_tb.sv
module bypass_mailbox_tb_top;
  localparam int W = 18;
  localparam int NV = 6;
  localparam logic [2*W-1:0] VECS [NV] = '{
    {18'h00001, 18'h3FFFF}, {18'h2AAAA, 18'h15555}, {18'h3FFFF, 18'h00000},
    {18'h12345, 18'h0ABCD}, {18'h00000, 18'h3C3C3}, {18'h1F0F0, 18'h20001}};

  logic clk_a = 0, clk_b = 0, rst_n = 1;
  logic a_bypass = 0, a_en_n = 1, a_dir = 0, b_en_n = 1, b_dir = 0;
  logic [W-1:0] a_wdata = '0, b_wdata = '0;
  logic [W-1:0] a_rdata, b_rdata;
  logic a_ab_full_n, a_ba_empty_n, b_ab_empty_n, b_ba_full_n, b_byp_n;
  int checks = 0, fails = 0;
  bit done = 0;

  always #5 clk_a = ~clk_a;
  always #7 clk_b = ~clk_b;

  bypass_mailbox #(.DATA_W(W)) dut_i (.*);

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic a_op(input logic dir, input logic [W-1:0] d, input logic en_n);
    @(negedge clk_a); a_en_n = en_n; a_dir = dir; a_wdata = d;
    @(negedge clk_a); a_en_n = 1;
  endtask

  task automatic b_op(input logic dir, input logic [W-1:0] d, input logic en_n);
    @(negedge clk_b); b_en_n = en_n; b_dir = dir; b_wdata = d;
    @(negedge clk_b); b_en_n = 1;
  endtask

  // wait for a flag to reach a value on the given side; 1 = A, 0 = B
  task automatic wait_for(input string req, input bit side_a, ref logic sig, input logic val);
    int n = 0;
    while (sig !== val && n < 20) begin
      if (side_a) @(negedge clk_a); else @(negedge clk_b);
      n++;
    end
    chk(req, sig, val);
  endtask

  task automatic do_reset();
    @(negedge clk_a); rst_n = 0;
    repeat (3) @(negedge clk_b);
    chk("R10 a_ab_full_n", a_ab_full_n, 1'b1);
    chk("R10 a_ba_empty_n", a_ba_empty_n, 1'b0);
    chk("R10 b_ab_empty_n", b_ab_empty_n, 1'b0);
    chk("R10 b_ba_full_n", b_ba_full_n, 1'b1);
    chk("R10 b_byp_n", b_byp_n, 1'b1);
    @(negedge clk_a); rst_n = 1;
  endtask

  initial begin
    #1;
    do_reset();
    // R9: bypass indicator follows a_bypass
    @(negedge clk_a); a_bypass = 1;
    chk("R9 not yet", b_byp_n, 1'b1);
    wait_for("R9 on", 0, b_byp_n, 1'b0);

    // Vector loop: both directions each step
    for (int i = 0; i < NV; i++) begin
      logic [W-1:0] vab, vba;
      vab = VECS[i][2*W-1:W]; vba = VECS[i][W-1:0];
      a_op(1'b0, vab, 1'b0);
      chk("R1 full after write", a_ab_full_n, 1'b0);
      b_op(1'b0, vba, 1'b0);
      chk("R4 b full after write", b_ba_full_n, 1'b0);
      wait_for("R2 word waiting", 0, b_ab_empty_n, 1'b1);
      b_op(1'b1, '0, 1'b0);
      chk("R11 b_rdata", b_rdata, vab);
      chk("R2 wait cleared", b_ab_empty_n, 1'b0);
      wait_for("R4 a word waiting", 1, a_ba_empty_n, 1'b1);
      a_op(1'b1, '0, 1'b0);
      chk("R11 a_rdata", a_rdata, vba);
      chk("R4 a wait cleared", a_ba_empty_n, 1'b0);
      wait_for("R3 full released", 1, a_ab_full_n, 1'b1);
      wait_for("R4 b full released", 0, b_ba_full_n, 1'b1);
    end

    // R5: write to occupied slot dropped
    a_op(1'b0, 18'h11111, 1'b0);
    a_op(1'b0, 18'h22222, 1'b0);
    chk("R5 still full", a_ab_full_n, 1'b0);
    wait_for("R5 waiting", 0, b_ab_empty_n, 1'b1);
    b_op(1'b1, '0, 1'b0);
    chk("R5 first word kept", b_rdata, 18'h11111);
    wait_for("R5 released", 1, a_ab_full_n, 1'b1);
    repeat (4) @(negedge clk_b);
    chk("R5 no second word", b_ab_empty_n, 1'b0);

    // R6: read from empty dropped
    b_op(1'b1, '0, 1'b0);
    chk("R6 b_rdata kept", b_rdata, 18'h11111);
    chk("R6 b flag", b_ab_empty_n, 1'b0);
    a_op(1'b1, '0, 1'b0);
    chk("R6 a_rdata kept", a_rdata, VECS[NV-1][W-1:0]);

    // R7: enable high does nothing
    a_op(1'b0, 18'h33333, 1'b1);
    chk("R7 a no load", a_ab_full_n, 1'b1);
    b_op(1'b0, 18'h33333, 1'b1);
    chk("R7 b no load", b_ba_full_n, 1'b1);
    repeat (4) @(negedge clk_b);
    chk("R7 nothing waiting", b_ab_empty_n, 1'b0);

    // R10 mid-run: reset with a word pending
    a_op(1'b0, 18'h0F0F0, 1'b0);
    do_reset();
    chk("R10 full after reset", a_ab_full_n, 1'b1);

    // R8: bypass off blocks transfers
    a_bypass = 0;
    repeat (4) @(negedge clk_b);
    chk("R9 off", b_byp_n, 1'b1);
    a_op(1'b0, 18'h04444, 1'b0);
    chk("R8 a write ignored", a_ab_full_n, 1'b1);
    b_op(1'b0, 18'h05555, 1'b0);
    chk("R8 b write ignored", b_ba_full_n, 1'b1);
    repeat (4) @(negedge clk_a);
    chk("R8 nothing to A", a_ba_empty_n, 1'b0);

    // R9 off transition after being on
    a_bypass = 1;
    wait_for("R9 on again", 0, b_byp_n, 1'b0);
    @(negedge clk_a); a_bypass = 0;
    wait_for("R9 off again", 0, b_byp_n, 1'b1);

    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    #200000;
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule